// File: doc/BRIEF.md
# Packet-Programmed Synchronous Rate Synthesizer

This block turns a short ASCII command frame, received one byte at a time over a valid/data stream, into a periodic pulse train. The pulse train is derived from the 10 MHz reference clock that also runs the block. The frame carries a mode digit and two divisors written as hexadecimal text. Two cascaded down-counter stages divide the reference. Each stage divides by its programmed value plus one, so the output period is (n1+1)·(n2+1) reference clocks.

There are two modes. In the free-running mode a new setting takes effect as soon as the frame is accepted, and the 1PPS input plays no part. In the synchronous mode (mode digit '5') every rising edge of the 1PPS input restarts both stages, so the pulse train keeps a fixed phase to the second. In this mode a newly received setting waits for the next 1PPS edge before it is used. The 1PPS input is assumed to be already synchronous to the clock.

Top module: `rate_synth`

## Requirements
- R1: A frame is accepted only if it is exactly SOH (0x01), 'F' (0x46), one mode digit '0'..'9', four hex digits of n1 (most significant first), four hex digits of n2, then ETB (0x17). Only bytes with `rx_valid` high count. On acceptance `pkt_ok` is high for one cycle, in the cycle after the ETB byte is sampled. While the block is waiting for SOH, any other byte is dropped without raising a flag.
- R2: Hex digits are accepted in upper case ('A'..'F') and in lower case ('a'..'f').
- R3: Any of these aborts the frame: a wrong second byte, a mode byte that is not a decimal digit, a non-hex byte in a digit position, or a final byte other than ETB. On an abort `pkt_err` is high for one cycle, in the cycle after the offending byte. The parser then waits for SOH again and the active setting is left unchanged. `pkt_ok` and `pkt_err` are never high together.
- R4: With a mode digit other than '5', the new n1/n2 take effect at once and the pulse period becomes (n1+1)·(n2+1) clocks. In this mode `pps` has no effect on the pulse phase.
- R5: In mode '5', the rising edge of `pps` reloads both stages. The first pulse after that edge comes on the (n1+1)·(n2+1)-th rising clock edge, counting the edge that first samples `pps` high as edge 1.
- R6: Stage 1 divides the clock by n1+1. Stage 2 counts only stage-1 wraps and divides them by n2+1. A divisor of zero divides by one.
- R7: A setting accepted in mode '5' is held pending until the next rising edge of `pps`. Until then the previous setting keeps generating pulses.
- R8: After reset the block is in free-running mode with n1=9 and n2=99, so the pulse period is 1000 clocks, and both flags are low.
- R9: `rate_pulse` is one clock wide whenever the period is greater than one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 10 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte on `rx_data` is valid this cycle |
| rx_data | input | 8 | Command byte stream |
| pps | input | 1 | One-pulse-per-second reference, synchronous to `clk` |
| rate_pulse | output | 1 | Generated rate pulse |
| pkt_ok | output | 1 | One-cycle pulse: frame accepted |
| pkt_err | output | 1 | One-cycle pulse: frame aborted |

## Verification
The embedded assertions check the cycle-level behaviour on every clock:
- A stage reloads to the loaded value, or to its terminal value after a wrap, and a stage that is not enabled holds its count.
- The two flags are mutually exclusive, and each accepted frame gives a single `pkt_ok` cycle.
- A free-mode setting lands in the active registers one cycle after acceptance.
- A pending synchronous setting leaves the active setting untouched until a `pps` edge.
- The output pulse is single-cycle.

Only the bench scenarios can show the end-to-end results:
- The resulting pulse periods for many divisor pairs.
- The exact distance from a `pps` edge to the first pulse.
- That aborted frames keep the old period.
- That `pps` leaves the phase alone in free mode.

// File: rtl/rsyn_pkg.sv
package rsyn_pkg;

  localparam logic [7:0] CH_SOH  = 8'h01;
  localparam logic [7:0] CH_ETB  = 8'h17;
  localparam logic [7:0] CH_ID   = 8'h46;  // 'F'
  localparam logic [7:0] CH_SYNC = 8'h35;  // '5'

  typedef enum logic [2:0] {
    PS_HUNT,
    PS_ID,
    PS_MODE,
    PS_DIGIT,
    PS_TAIL
  } pstate_t;

  // Returns {valid, nibble} for an ASCII hex character.
  function automatic logic [4:0] hex_decode(input logic [7:0] ch);
    logic [4:0] r;
    r = 5'd0;
    if (ch >= 8'h30 && ch <= 8'h39)      r = {1'b1, 4'(ch - 8'h30)};
    else if (ch >= 8'h41 && ch <= 8'h46) r = {1'b1, 4'(ch - 8'h41 + 8'd10)};
    else if (ch >= 8'h61 && ch <= 8'h66) r = {1'b1, 4'(ch - 8'h61 + 8'd10)};
    return r;
  endfunction

  function automatic logic is_decimal(input logic [7:0] ch);
    return (ch >= 8'h30) && (ch <= 8'h39);
  endfunction

endpackage

// File: rtl/rsyn_parser.sv
module rsyn_parser
  import rsyn_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W    = 4 * DIGITS,
  localparam int NDIG = 2 * DIGITS,
  localparam int IW   = $clog2(NDIG)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [7:0]   in_byte,
  output logic         done,
  output logic         err,
  output logic         cfg_sync,
  output logic [W-1:0] cfg_n1,
  output logic [W-1:0] cfg_n2
);

  pstate_t          state;
  logic [IW-1:0]    idx;
  logic [2*W-1:0]   shreg;
  logic             mode_q;

  logic [4:0] hx;
  logic       hex_ok;
  logic       dec_ok;
  logic       last_digit;

  assign hx         = hex_decode(in_byte);
  assign hex_ok     = hx[4];
  assign dec_ok     = is_decimal(in_byte);
  assign last_digit = (idx == IW'(NDIG - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= PS_HUNT;
      idx      <= '0;
      shreg    <= '0;
      mode_q   <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      cfg_sync <= 1'b0;
      cfg_n1   <= '0;
      cfg_n2   <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (in_valid) begin
        case (state)
          PS_HUNT: if (in_byte == CH_SOH) state <= PS_ID;
          PS_ID: begin
            if (in_byte == CH_ID) state <= PS_MODE;
            else begin
              err   <= 1'b1;
              state <= PS_HUNT;
            end
          end
          PS_MODE: begin
            if (dec_ok) begin
              mode_q <= (in_byte == CH_SYNC);
              idx    <= '0;
              state  <= PS_DIGIT;
            end else begin
              err   <= 1'b1;
              state <= PS_HUNT;
            end
          end
          PS_DIGIT: begin
            if (hex_ok) begin
              shreg <= {shreg[2*W-5:0], hx[3:0]};
              idx   <= idx + 1'b1;
              if (last_digit) state <= PS_TAIL;
            end else begin
              err   <= 1'b1;
              state <= PS_HUNT;
            end
          end
          PS_TAIL: begin
            if (in_byte == CH_ETB) begin
              done     <= 1'b1;
              cfg_sync <= mode_q;
              cfg_n1   <= shreg[2*W-1:W];
              cfg_n2   <= shreg[W-1:0];
            end else begin
              err <= 1'b1;
            end
            state <= PS_HUNT;
          end
          default: state <= PS_HUNT;
        endcase
      end
    end
  end

  // R3: accept and abort never in the same cycle
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R1: an accepted frame yields a single-cycle flag
  a_r1_ok_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/rsyn_stage.sv
module rsyn_stage #(
  parameter int          W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] term,
  output logic         tick
);

  logic [W-1:0] cnt;

  assign tick = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= RST_VAL;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= term;
    else if (en)   cnt <= cnt - 1'b1;
  end

  // R5: a reload places the new terminal value in the counter
  a_r5_stage_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));

  // R6: after a wrap the stage restarts from its terminal value
  a_r6_stage_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> cnt == $past(term));

  // R6: a stage that is not enabled keeps its count
  a_r6_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !en) |=> $stable(cnt));

endmodule

// File: rtl/rate_synth.sv
module rate_synth
  import rsyn_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int RST_N1 = 9,
  parameter int RST_N2 = 99,
  localparam int W     = 4 * DIGITS,
  localparam int NSTG  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       pps,
  output logic       rate_pulse,
  output logic       pkt_ok,
  output logic       pkt_err
);

  logic         cfg_sync;
  logic [W-1:0] cfg_n1, cfg_n2;

  rsyn_parser #(.DIGITS(DIGITS)) u_parser (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_valid),
    .in_byte  (rx_data),
    .done     (pkt_ok),
    .err      (pkt_err),
    .cfg_sync (cfg_sync),
    .cfg_n1   (cfg_n1),
    .cfg_n2   (cfg_n2)
  );

  logic         pps_q;
  logic         pps_rise;
  logic         act_sync, pend_vld;
  logic [W-1:0] act_n1, act_n2, pend_n1, pend_n2;
  logic         apply_now;   // free-mode frame accepted
  logic         apply_pps;   // synchronous restart on 1PPS
  logic         reload;
  logic [W-1:0] nxt_n1, nxt_n2;

  assign pps_rise  = pps && !pps_q;
  assign apply_now = pkt_ok && !cfg_sync;
  assign apply_pps = pps_rise && !pkt_ok && (pend_vld || act_sync);
  assign reload    = apply_now || apply_pps;
  assign nxt_n1    = apply_now ? cfg_n1 : (pend_vld ? pend_n1 : act_n1);
  assign nxt_n2    = apply_now ? cfg_n2 : (pend_vld ? pend_n2 : act_n2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pps_q    <= 1'b0;
      act_sync <= 1'b0;
      act_n1   <= W'(RST_N1);
      act_n2   <= W'(RST_N2);
      pend_vld <= 1'b0;
      pend_n1  <= '0;
      pend_n2  <= '0;
    end else begin
      pps_q <= pps;
      if (pkt_ok) begin
        if (cfg_sync) begin
          pend_vld <= 1'b1;
          pend_n1  <= cfg_n1;
          pend_n2  <= cfg_n2;
        end else begin
          pend_vld <= 1'b0;
          act_sync <= 1'b0;
          act_n1   <= cfg_n1;
          act_n2   <= cfg_n2;
        end
      end else if (apply_pps && pend_vld) begin
        pend_vld <= 1'b0;
        act_sync <= 1'b1;
        act_n1   <= pend_n1;
        act_n2   <= pend_n2;
      end
    end
  end

  logic [W-1:0] load_v [NSTG];
  logic [W-1:0] term_v [NSTG];
  logic [NSTG-1:0] en_v, tick_v;

  assign load_v[0] = nxt_n1;
  assign load_v[1] = nxt_n2;
  assign term_v[0] = act_n1;
  assign term_v[1] = act_n2;

  generate
    for (genvar s = 0; s < NSTG; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign en_v[s] = 1'b1;
      end else begin : g_next
        assign en_v[s] = tick_v[s-1];
      end
      rsyn_stage #(
        .W       (W),
        .RST_VAL ((s == 0) ? W'(RST_N1) : W'(RST_N2))
      ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_v[s]),
        .load     (reload),
        .load_val (load_v[s]),
        .term     (term_v[s]),
        .tick     (tick_v[s])
      );
    end
  endgenerate

  assign rate_pulse = tick_v[NSTG-1];

  // R4: a free-mode frame lands in the active setting on the next cycle
  a_r4_free_apply: assert property (@(posedge clk) disable iff (!rst_n)
    apply_now |=> (act_n1 == $past(cfg_n1)) && (act_n2 == $past(cfg_n2)) && !act_sync);

  // R7: a pending synchronous setting waits for the 1PPS edge
  a_r7_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && !pps_rise && !pkt_ok) |=> $stable(act_n1) && $stable(act_n2) && pend_vld);

  // R9: output pulse is one cycle wide when the period exceeds one
  a_r9_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_pulse && !reload && (act_n1 != '0 || act_n2 != '0)) |=> !rate_pulse);

endmodule

// File: tb/rate_synth_test.sv
module rate_synth_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       pps = 1'b0;
  logic       rate_pulse, pkt_ok, pkt_err;

  int checks = 0;
  int errors = 0;
  logic seen_ok, seen_err;
  logic [7:0] fr [12];

  always #10 clk = ~clk;   // 50 MHz

  rate_synth uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .pps(pps), .rate_pulse(rate_pulse), .pkt_ok(pkt_ok), .pkt_err(pkt_err)
  );

  function automatic int exp_period(int a, int b);
    return (a + 1) * (b + 1);
  endfunction

  function automatic logic [7:0] hexc(int nib, bit upper);
    if (nib < 10) return 8'(8'h30 + nib);
    return 8'((upper ? 8'h41 : 8'h61) + nib - 10);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    seen_ok  = seen_ok | pkt_ok;
    seen_err = seen_err | pkt_err;
  endtask

  task automatic build(logic [7:0] mode, int a, int b, bit upper);
    fr[0] = 8'h01;
    fr[1] = 8'h46;
    fr[2] = mode;
    for (int i = 0; i < 4; i++) begin
      fr[3+i] = hexc((a >> (12 - 4*i)) & 15, upper);
      fr[7+i] = hexc((b >> (12 - 4*i)) & 15, upper);
    end
    fr[11] = 8'h17;
  endtask

  task automatic send_frame();
    seen_ok  = 1'b0;
    seen_err = 1'b0;
    for (int i = 0; i < 12; i++) send_byte(fr[i]);
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!rate_pulse && n < 5000);
  endtask

  task automatic period(output int p);
    int d;
    wait_pulse(d);
    wait_pulse(p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p, n, a, b;
    logic [7:0] m;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 pkt_ok after reset", pkt_ok, 0);
    chk("R8 pkt_err after reset", pkt_err, 0);
    period(p);
    chk("R8 reset period", p, exp_period(9, 99));
    @(negedge clk);
    chk("R9 pulse width", rate_pulse, 0);

    // R1: noise while hunting is silently dropped
    seen_ok = 1'b0; seen_err = 1'b0;
    send_byte(8'h5A); send_byte(8'h17); send_byte(8'h46);
    chk("R1 noise no ok", seen_ok, 0);
    chk("R1 noise no err", seen_err, 0);

    build(8'h30, 3, 4, 1'b1);
    send_frame();
    chk("R1 accept", seen_ok, 1);
    chk("R1 accept no err", seen_err, 0);
    period(p);
    chk("R4 free period", p, exp_period(3, 4));

    // R2 R4 R6: random divisors, mixed case
    for (int k = 0; k < 6; k++) begin
      a = $urandom_range(0, 15);
      b = $urandom_range(0, 15);
      m = 8'(8'h30 + $urandom_range(0, 9));
      if (m == 8'h35) m = 8'h31;
      build(m, a, b, 1'($urandom_range(0, 1)));
      send_frame();
      chk("R2 random accept", seen_ok, 1);
      period(p);
      chk("R6 random period", p, exp_period(a, b));
    end

    build(8'h30, 0, 0, 1'b0); send_frame();
    period(p); chk("R6 zero divisors", p, 1);
    build(8'h30, 0, 5, 1'b0); send_frame();
    period(p); chk("R6 zero n1", p, 6);
    build(8'h30, 5, 0, 1'b1); send_frame();
    period(p); chk("R6 zero n2", p, 6);

    // R3: aborted frames
    build(8'h32, 1, 2, 1'b1); send_frame();
    build(8'h31, 7, 7, 1'b1); fr[1] = 8'h47; send_frame();
    chk("R3 wrong id err", seen_err, 1);
    chk("R3 wrong id ok", seen_ok, 0);
    build(8'h31, 7, 7, 1'b1); fr[5] = 8'h47; send_frame();
    chk("R3 bad hex err", seen_err, 1);
    build(8'h31, 7, 7, 1'b1); fr[2] = 8'h58; send_frame();
    chk("R3 bad mode err", seen_err, 1);
    build(8'h31, 7, 7, 1'b1); fr[11] = 8'h03; send_frame();
    chk("R3 missing ETB err", seen_err, 1);
    chk("R3 missing ETB ok", seen_ok, 0);
    period(p);
    chk("R3 period kept", p, exp_period(1, 2));

    // R4: pps ignored in free mode
    build(8'h39, 2, 2, 1'b1); send_frame();
    wait_pulse(n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 3) pps = 1'b1;
    end while (!rate_pulse && n < 5000);
    chk("R4 pps ignored", n, 9);
    pps = 1'b0;
    repeat (3) @(negedge clk);

    // R7 then R5
    build(8'h35, 4, 3, 1'b0); send_frame();
    chk("R7 sync accept", seen_ok, 1);
    period(p);
    chk("R7 old setting kept", p, 9);
    @(negedge clk);
    pps = 1'b1;
    wait_pulse(n);
    chk("R5 first pulse", n, exp_period(4, 3));
    period(p);
    chk("R5 sync period", p, exp_period(4, 3));
    pps = 1'b0;
    repeat ($urandom_range(3, 15)) @(negedge clk);
    pps = 1'b1;
    wait_pulse(n);
    chk("R5 realign", n, exp_period(4, 3));
    pps = 1'b0;
    repeat (3) @(negedge clk);

    build(8'h35, 0, 0, 1'b0); send_frame();
    @(negedge clk);
    pps = 1'b1;
    wait_pulse(n);
    chk("R5 sync divide by one", n, 1);
    pps = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule